// File: doc/BRIEF.md
# Serial Byte Port with Wait-Mode Clock Gating

This block is an 8-bit serial peripheral port that acts as either the clock-driving side or the clock-following side of a four-wire serial link. It uses clock mode 0 only. Software uses a small register file: a control register, a divisor register, a status register and a data register. Software starts master transfers by writing the data register. It learns that a byte is complete from a sticky flag and an optional interrupt line.

The block also takes a CPU wait input. When the stop-in-wait control bit is clear, wait has no effect. When the bit is set, wait behaves differently in each role. A master transfer in flight freezes at its current bit and serial clock level, then continues when wait drops. A slave keeps shifting on the external clock, but it does not raise its flag while waiting. It also keeps the transmit source it had when wait began. On leaving wait, any byte completed during wait raises the flag once, and the last such byte becomes the readable receive data.

Register map (`reg_addr`): 0 control, 1 divisor, 2 status, 3 data. The control bits are: bit 0 enable, bit 1 master select, bit 2 stop-in-wait, bit 3 echo source (slave sends the byte it last received instead of the data register), and bit 4 interrupt enable. The status bits are: bit 7 transfer-complete flag, bit 1 held-over byte pending, and bit 0 busy. A data write loads the transmit byte. A data read returns the receive byte. Reads are combinational from `reg_addr` and take effect at the clock edge where `reg_rd` is high.

Top module: `spi_waitgate`

## Requirements
- R1: After reset, control, divisor, status and receive data all read 0, and `irq`, `m_sck_o` and `s_miso_o` are low.
- R2: While enable (control bit 0) is clear, registers still accept writes and read back. A data write starts no transfer: `m_sck_o` stays low and status busy (bit 0) stays 0.
- R3: In master mode, a data write while idle sends the byte MSB first on `m_mosi_o`. Data changes after falling `m_sck_o` edges, and `m_miso_i` is sampled on rising edges. The SCK period is 2*(divisor+1) system clocks, so the divisor value runs from 0 (period 2) to 127 (period 256). After the 8th falling edge, the received byte is readable at address 3 and status bit 7 is set.
- R4: The flag clears only when the data register is read after a status read that saw the flag set. A data read without such a prior status read leaves it set.
- R5: `irq` is high exactly while the flag is set and control bit 4 is set.
- R6: With stop-in-wait clear, asserting `wait_in` changes nothing: a master transfer keeps its SCK period and completes normally.
- R7: With stop-in-wait set, a master in wait holds `m_sck_o` at its level and raises no flag. After wait is released, it resumes from the same bit, and the byte completes intact.
- R8: As slave, with `s_ss_n_i` low, the block samples `s_mosi_i` on rising `s_sck_i` and shifts `s_miso_o` on falling edges, MSB first. It sends the data register in every frame, sets the flag and makes the received byte readable.
- R9: As slave with echo (control bit 3) set, each frame sends the byte received in the previous frame.
- R10: As slave with stop-in-wait set, frames keep shifting during wait but the flag stays 0. On release, the flag sets once, and data reads the last byte completed during wait.
- R11: During slave wait, the transmit source is fixed at its state at wait entry. Data writes and echo-bit changes made during wait do not alter the bytes sent, and take effect only after wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| wait_in | input | 1 | CPU wait-mode indication |
| irq | output | 1 | Transfer-complete interrupt |
| m_sck_o | output | 1 | Serial clock driven in master mode |
| m_mosi_o | output | 1 | Serial data out in master mode |
| m_miso_i | input | 1 | Serial data in for master mode |
| s_sck_i | input | 1 | External serial clock in slave mode |
| s_ss_n_i | input | 1 | Active-low slave select |
| s_mosi_i | input | 1 | Serial data in for slave mode |
| s_miso_o | output | 1 | Serial data out in slave mode |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 7-bit divisor field and a two-stage input synchronizer. This puts both ends of the divisor range within reach: a value of 0 gives a 2-cycle SCK, and 127 gives a 256-cycle SCK, whose 2048-cycle frame still fits easily. The two synchronizer stages and the chosen external clock rate leave the slave data a known settle time before each rising edge. The 8-bit width lets the bench step through held-over and echoed byte sequences one byte at a time.

// File: rtl/spi_wg_pkg.sv
`timescale 1ns/1ps
// Shared register addresses and control bit positions for the serial port.
// Assumes: control register is CTRL_W bits wide and data width is at least CTRL_W.
package spi_wg_pkg;
    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_BAUD = 2'd1,
        RA_STAT = 2'd2,
        RA_DATA = 2'd3
    } reg_addr_e;

    localparam int CTRL_W  = 5;
    localparam int CB_EN   = 0;
    localparam int CB_MST  = 1;
    localparam int CB_SWAI = 2;
    localparam int CB_ECHO = 3;
    localparam int CB_IE   = 4;
endpackage

// File: rtl/spi_wg_regs.sv
`timescale 1ns/1ps
// Register file, completion flag, held-over byte and interrupt.
// Assumes: done is a one-cycle pulse from the active shift engine;
// gating is high while stop-in-wait is in force.
module spi_wg_regs
    import spi_wg_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          gating,
    input  logic          busy,
    input  logic          done,
    input  logic [DW-1:0] done_byte,
    output logic          en,
    output logic          mst,
    output logic          swai,
    output logic          echo,
    output logic [BW-1:0] baud,
    output logic [DW-1:0] txd,
    output logic          start,
    output logic          flag,
    output logic          pend,
    output logic          irq
);
    logic [CTRL_W-1:0] ctrl;
    logic [DW-1:0]     rxd;
    logic [DW-1:0]     pbyte;
    logic              armed;
    logic              rd_stat, rd_data, clr;

    assign en      = ctrl[CB_EN];
    assign mst     = ctrl[CB_MST];
    assign swai    = ctrl[CB_SWAI];
    assign echo    = ctrl[CB_ECHO];
    assign irq     = flag & ctrl[CB_IE];
    assign rd_stat = rd && (reg_addr_e'(addr) == RA_STAT);
    assign rd_data = rd && (reg_addr_e'(addr) == RA_DATA);
    assign clr     = rd_data && armed;
    assign start   = wr && (reg_addr_e'(addr) == RA_DATA) && en && mst && !busy && !gating;

    // Read multiplexer: combinational view of the addressed register.
    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_CTRL: rdata[CTRL_W-1:0] = ctrl;
            RA_BAUD: rdata[BW-1:0]     = baud;
            RA_STAT: begin
                rdata[DW-1] = flag;
                rdata[1]    = pend;
                rdata[0]    = busy;
            end
            RA_DATA: rdata = rxd;
            default: rdata = '0;
        endcase
    end

    // Register writes, flag clear handshake, and completion capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            baud  <= '0;
            txd   <= '0;
            rxd   <= '0;
            pbyte <= '0;
            flag  <= 1'b0;
            pend  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (wr) begin
                case (reg_addr_e'(addr))
                    RA_CTRL: ctrl <= wdata[CTRL_W-1:0];
                    RA_BAUD: baud <= wdata[BW-1:0];
                    RA_DATA: txd  <= wdata;
                    default: ;
                endcase
            end
            if (rd_stat && flag) armed <= 1'b1;
            if (clr) begin
                flag  <= 1'b0;
                armed <= 1'b0;
            end
            if (done && gating) begin
                pend  <= 1'b1;
                pbyte <= done_byte;
            end else if (done) begin
                flag <= 1'b1;
                rxd  <= done_byte;
                pend <= 1'b0;
            end else if (pend && !gating) begin
                flag <= 1'b1;
                rxd  <= pbyte;
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_wg_master.sv
`timescale 1ns/1ps
// Clock-driving shift engine, mode 0, MSB first.
// Half SCK period is half+1 system clocks; hold freezes all state mid-byte.
// Assumes: start is only pulsed while idle; run low clears the engine.
module spi_wg_master #(
    parameter int DW = 8,
    parameter int BW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          hold,
    input  logic          start,
    input  logic [DW-1:0] txd,
    input  logic [BW-1:0] half,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx
);
    localparam int CW = $clog2(DW);

    logic [DW-1:0] sh;
    logic [BW-1:0] divcnt;
    logic [CW-1:0] bitn;

    assign mosi = sh[DW-1];

    // Divider, edge generation, shifting and completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sh     <= '0;
            rx     <= '0;
            divcnt <= '0;
            bitn   <= '0;
            sck    <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy   <= 1'b1;
                sh     <= txd;
                bitn   <= '0;
                divcnt <= '0;
                sck    <= 1'b0;
            end else if (busy && !hold) begin
                if (divcnt == half) begin
                    divcnt <= '0;
                    if (!sck) begin
                        sck <= 1'b1;
                        rx  <= {rx[DW-2:0], miso};
                    end else begin
                        sck  <= 1'b0;
                        sh   <= {sh[DW-2:0], 1'b0};
                        bitn <= bitn + 1'b1;
                        if (bitn == CW'(DW-1)) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                end else begin
                    divcnt <= divcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_wg_slave.sv
`timescale 1ns/1ps
// Clock-following shift engine, mode 0, MSB first.
// Synchronises the external clock, select and data, samples on rising
// edges and shifts on falling ones. While deselected it preloads the
// transmit source; after each full byte it reloads at the next falling edge.
// Assumes: external half period is several system clocks long.
module spi_wg_slave #(
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          sck_i,
    input  logic          ss_n_i,
    input  logic          si_i,
    input  logic          src_echo,
    input  logic [DW-1:0] src_tx,
    output logic          so,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx
);
    localparam int CW = $clog2(DW);

    logic [SYNC-1:0] sck_p, ss_p, si_p;
    logic            sck_d;
    logic [DW-1:0]   rxs, txs;
    logic [CW-1:0]   bitn;
    logic            reload;
    logic            sel, rise, fall, si_q;
    logic [DW-1:0]   src;

    assign sel  = run && !ss_p[SYNC-1];
    assign rise = sck_p[SYNC-1] && !sck_d;
    assign fall = !sck_p[SYNC-1] && sck_d;
    assign si_q = si_p[SYNC-1];
    assign src  = src_echo ? rx : src_tx;
    assign so   = sel ? txs[DW-1] : 1'b0;
    assign busy = sel && (bitn != '0);

    // Input synchronisers and previous-clock register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p <= '0;
            ss_p  <= '1;
            si_p  <= '0;
            sck_d <= 1'b0;
        end else begin
            sck_p <= {sck_p[SYNC-2:0], sck_i};
            ss_p  <= {ss_p[SYNC-2:0], ss_n_i};
            si_p  <= {si_p[SYNC-2:0], si_i};
            sck_d <= sck_p[SYNC-1];
        end
    end

    // Frame shifting, byte completion and transmit reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxs    <= '0;
            txs    <= '0;
            rx     <= '0;
            bitn   <= '0;
            reload <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!sel) begin
                bitn   <= '0;
                txs    <= src;
                reload <= 1'b0;
            end else begin
                if (rise) begin
                    rxs  <= {rxs[DW-2:0], si_q};
                    bitn <= bitn + 1'b1;
                    if (bitn == CW'(DW-1)) begin
                        done   <= 1'b1;
                        rx     <= {rxs[DW-2:0], si_q};
                        reload <= 1'b1;
                    end
                end
                if (fall) begin
                    if (reload) begin
                        txs    <= src;
                        reload <= 1'b0;
                    end else begin
                        txs <= {txs[DW-2:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_waitgate.sv
`timescale 1ns/1ps
// Serial byte port top: joins the register file with the master and slave
// engines, derives wait gating and freezes the slave transmit source.
// Assumes: only one engine runs at a time, chosen by the master bit.
module spi_waitgate #(
    parameter int DW   = 8,
    parameter int BW   = 7,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          wait_in,
    output logic          irq,
    output logic          m_sck_o,
    output logic          m_mosi_o,
    input  logic          m_miso_i,
    input  logic          s_sck_i,
    input  logic          s_ss_n_i,
    input  logic          s_mosi_i,
    output logic          s_miso_o
);
    logic          en, mst, swai, echo, start, flag, pend, gating;
    logic [BW-1:0] baud;
    logic [DW-1:0] txd;
    logic          m_busy, m_done, s_busy, s_done;
    logic [DW-1:0] m_rx, s_rx;
    logic          snap_echo;
    logic [DW-1:0] snap_tx;

    assign gating = en && swai && wait_in;

    spi_wg_regs #(.DW(DW), .BW(BW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .gating(gating),
        .busy(m_busy | s_busy), .done(mst ? m_done : s_done),
        .done_byte(mst ? m_rx : s_rx), .en(en), .mst(mst), .swai(swai),
        .echo(echo), .baud(baud), .txd(txd), .start(start), .flag(flag),
        .pend(pend), .irq(irq)
    );

    spi_wg_master #(.DW(DW), .BW(BW)) u_mst (
        .clk(clk), .rst_n(rst_n), .run(en && mst), .hold(gating),
        .start(start), .txd(reg_wdata), .half(baud), .miso(m_miso_i),
        .sck(m_sck_o), .mosi(m_mosi_o), .busy(m_busy), .done(m_done), .rx(m_rx)
    );

    // Snapshot of the slave transmit source, refreshed whenever not gated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_echo <= 1'b0;
            snap_tx   <= '0;
        end else if (!gating) begin
            snap_echo <= echo;
            snap_tx   <= txd;
        end
    end

    spi_wg_slave #(.DW(DW), .SYNC(SYNC)) u_slv (
        .clk(clk), .rst_n(rst_n), .run(en && !mst), .sck_i(s_sck_i),
        .ss_n_i(s_ss_n_i), .si_i(s_mosi_i),
        .src_echo(gating ? snap_echo : echo), .src_tx(gating ? snap_tx : txd),
        .so(s_miso_o), .busy(s_busy), .done(s_done), .rx(s_rx)
    );
endmodule

// File: rtl/spi_waitgate_chk.sv
`timescale 1ns/1ps
// Property checker for the serial port, attached to the top by bind.
// Assumes: reset is held for at least one clock before release.
module spi_waitgate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       gating,
    input logic       m_busy,
    input logic       m_sck,
    input logic       flag,
    input logic       pend,
    input logic       irq,
    input logic       reg_rd,
    input logic [1:0] reg_addr
);
    // R2: a disabled block has an idle master engine
    a_r2_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!m_sck && !m_busy));

    // R3: serial clock rests low whenever no master transfer runs
    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !m_busy |-> !m_sck);

    // R4: the flag only drops after a data register read
    a_r4_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(reg_rd && reg_addr == 2'd3));

    // R5: interrupt never shows without the flag
    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R7: serial clock level frozen while gated
    a_r7_sck_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (gating && $past(gating)) |-> $stable(m_sck));

    // R10: no flag rise while gated
    a_r10_no_flag_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gating) |-> !$rose(flag));

    // R10: a held-over byte becomes the flag right after release
    a_r10_release_once: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !gating) |=> (flag && !pend));
endmodule

bind spi_waitgate spi_waitgate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .gating(gating), .m_busy(m_busy),
    .m_sck(m_sck_o), .flag(flag), .pend(pend), .irq(irq),
    .reg_rd(reg_rd), .reg_addr(reg_addr)
);

// File: tb/spi_waitgate_test.sv
`timescale 1ns/1ps
// Self-checking bench with a behavioural model of both link partners.
module spi_waitgate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       wait_in = 1'b0;
    logic       irq, m_sck_o, m_mosi_o;
    logic       m_miso_i = 1'b0;
    logic       s_sck_i = 1'b0, s_ss_n_i = 1'b1, s_mosi_i = 1'b0;
    logic       s_miso_o;

    integer nerr = 0, nchk = 0;
    bit     finished = 1'b0;

    // Model state for the master-side partner
    logic [7:0] mbyte = 8'h00, mo_cap = 8'h00;
    integer     midx = 0, rises = 0, per_bad = 0, exp_per = 2;
    bit         per_on = 1'b0;
    realtime    last_rise = 0.0;
    // Model state for the slave-side partner
    logic [7:0] last_rx_model = 8'h00;

    always #2.5 clk = ~clk;

    spi_waitgate uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wait_in(wait_in), .irq(irq), .m_sck_o(m_sck_o), .m_mosi_o(m_mosi_o),
        .m_miso_i(m_miso_i), .s_sck_i(s_sck_i), .s_ss_n_i(s_ss_n_i),
        .s_mosi_i(s_mosi_i), .s_miso_o(s_miso_o)
    );

    // Partner of the master: captures MOSI and measures the SCK period
    always @(posedge m_sck_o) begin
        mo_cap = {mo_cap[6:0], m_mosi_o};
        if (per_on && rises > 0) begin
            if (($realtime - last_rise) > (exp_per * 5.0 + 0.5) ||
                ($realtime - last_rise) < (exp_per * 5.0 - 0.5)) per_bad++;
        end
        last_rise = $realtime;
        rises++;
    end
    always @(negedge m_sck_o) begin
        midx++;
        if (midx < 8) m_miso_i = mbyte[7-midx];
    end

    task automatic check(input bit ok, input string req, input integer act, input integer exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic clear_flag();
        logic [7:0] t;
        rd(2'd2, t);
        rd(2'd3, t);
    endtask

    task automatic wait_irq(input integer lim);
        for (int i = 0; i < lim && !irq; i++) @(negedge clk);
    endtask

    task automatic arm_master(input logic [7:0] mb, input integer b, input bit pchk);
        mbyte = mb; midx = 0; m_miso_i = mb[7];
        rises = 0; per_bad = 0; exp_per = 2 * (b + 1); per_on = pchk; mo_cap = 8'h00;
    endtask

    task automatic master_basic(input logic [7:0] tx, input logic [7:0] mb, input integer b);
        logic [7:0] d;
        wr(2'd1, b[7:0]);
        arm_master(mb, b, 1'b1);
        wr(2'd3, tx);
        wait_irq(20 * (b + 1) + 40);
        check(irq === 1'b1, "R5 irq after master byte", irq, 1);
        check(mo_cap == tx && rises == 8, "R3 MOSI bits", mo_cap, tx);
        check(per_bad == 0, "R3 SCK period", per_bad, 0);
        rd(2'd2, d);
        check(d[7] == 1'b1, "R3 flag set", d, 8'h80);
        rd(2'd3, d);
        check(d == mb, "R3 received byte", d, mb);
        check(irq === 1'b0, "R4 cleared after status then data", irq, 0);
    endtask

    task automatic slave_frame(input logic [7:0] m, output logic [7:0] got);
        for (int i = 0; i < 8; i++) begin
            s_mosi_i = m[7-i];
            repeat (8) @(negedge clk);
            got[7-i] = s_miso_o;
            s_sck_i = 1'b1;
            repeat (8) @(negedge clk);
            s_sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        last_rx_model = m;
    endtask

    task automatic reselect();
        s_ss_n_i = 1'b1;
        repeat (8) @(negedge clk);
        s_ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // Watchdog: an overrun counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, g, held;
        integer bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, d); check(d == 8'h00, "R1 control", d, 0);
        rd(2'd2, d); check(d == 8'h00, "R1 status", d, 0);
        rd(2'd3, d); check(d == 8'h00, "R1 data", d, 0);
        check(irq === 1'b0 && m_sck_o === 1'b0 && s_miso_o === 1'b0, "R1 outputs", {irq, m_sck_o, s_miso_o}, 0);

        // R2: disabled, registers usable, no transfer
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h05);
        rd(2'd1, d); check(d == 8'h05, "R2 divisor readback", d, 5);
        wr(2'd3, 8'h99);
        bad = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (m_sck_o !== 1'b0) bad++; end
        check(bad == 0, "R2 no SCK while disabled", bad, 0);
        rd(2'd2, d); check(d[0] == 1'b0, "R2 not busy", d, 0);

        // R3/R5: master transfers at divisor 3, 0 and 127
        wr(2'd0, 8'h13);
        master_basic(8'hA5, 8'h3C, 3);
        master_basic(8'h81, 8'h7E, 0);
        master_basic(8'h5B, 8'hC6, 127);

        // R4: data read without a prior status read keeps the flag
        arm_master(8'h11, 1, 1'b0);
        wr(2'd1, 8'h01);
        wr(2'd3, 8'h22);
        wait_irq(200);
        rd(2'd3, d);
        check(irq === 1'b1, "R4 flag kept without status read", irq, 1);
        clear_flag();
        check(irq === 1'b0, "R4 flag cleared by sequence", irq, 0);

        // R5: interrupt disabled, flag still set
        wr(2'd0, 8'h03);
        arm_master(8'h44, 1, 1'b0);
        wr(2'd3, 8'h66);
        repeat (100) @(negedge clk);
        rd(2'd2, d);
        check(irq === 1'b0 && d[7] == 1'b1, "R5 irq masked", {irq, d[7]}, 1);
        rd(2'd3, d);
        check(d == 8'h44, "R5 data with irq masked", d, 8'h44);

        // R6: wait with stop-in-wait clear changes nothing
        wr(2'd0, 8'h13);
        wait_in = 1'b1;
        master_basic(8'hC3, 8'h29, 2);
        wait_in = 1'b0;

        // R7: wait freezes the master mid-byte and resumes it
        wr(2'd0, 8'h17);
        wr(2'd1, 8'h03);
        arm_master(8'hB4, 3, 1'b0);
        wr(2'd3, 8'h6D);
        while (rises < 3) @(negedge clk);
        @(negedge clk);
        wait_in = 1'b1;
        @(negedge clk);
        held = {7'd0, m_sck_o};
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (m_sck_o !== held[0] || irq !== 1'b0) bad++;
        end
        check(bad == 0 && rises == 3, "R7 frozen in wait", bad, 0);
        wait_in = 1'b0;
        wait_irq(200);
        check(irq === 1'b1 && rises == 8, "R7 resumed to completion", rises, 8);
        check(mo_cap == 8'h6D, "R7 MOSI intact", mo_cap, 8'h6D);
        rd(2'd2, d);
        rd(2'd3, d);
        check(d == 8'hB4, "R7 received byte intact", d, 8'hB4);

        // R8: slave, data-register source
        wr(2'd0, 8'h11);
        wr(2'd3, 8'h3C);
        reselect();
        slave_frame(8'hA7, g);
        check(g == 8'h3C, "R8 slave sends data register", g, 8'h3C);
        check(irq === 1'b1, "R8 slave flag", irq, 1);
        rd(2'd2, d); rd(2'd3, d);
        check(d == 8'hA7, "R8 slave received", d, 8'hA7);
        slave_frame(8'h42, g);
        check(g == 8'h3C, "R8 same byte resent", g, 8'h3C);
        clear_flag();

        // R9: echo source
        s_ss_n_i = 1'b1;
        wr(2'd0, 8'h19);
        reselect();
        held = last_rx_model;
        slave_frame(8'h81, g);
        check(g == held, "R9 echo first frame", g, held);
        slave_frame(8'h7E, g);
        check(g == 8'h81, "R9 echo previous byte", g, 8'h81);
        clear_flag();

        // R10/R11: slave in wait, data-register source frozen
        s_ss_n_i = 1'b1;
        wr(2'd0, 8'h15);
        wr(2'd3, 8'h5A);
        repeat (4) @(negedge clk);
        wait_in = 1'b1;
        wr(2'd3, 8'h11);
        reselect();
        slave_frame(8'hC3, g);
        check(g == 8'h5A, "R11 frozen data frame 1", g, 8'h5A);
        slave_frame(8'h96, g);
        check(g == 8'h5A, "R11 frozen data frame 2", g, 8'h5A);
        rd(2'd2, d);
        check(irq === 1'b0 && d[7] == 1'b0 && d[1] == 1'b1, "R10 no flag in wait", d, 8'h02);
        wait_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd2, d);
        check(d[7] == 1'b1 && irq === 1'b1, "R10 flag on release", d, 8'h80);
        rd(2'd3, d);
        check(d == 8'h96, "R10 last byte latched", d, 8'h96);
        repeat (20) @(negedge clk);
        check(irq === 1'b0, "R10 flag raised once", irq, 0);
        reselect();
        slave_frame(8'h00, g);
        check(g == 8'h11, "R11 new data after wait", g, 8'h11);
        clear_flag();

        // R11: echo source frozen though the echo bit is cleared in wait
        s_ss_n_i = 1'b1;
        wr(2'd0, 8'h1D);
        repeat (8) @(negedge clk);
        wait_in = 1'b1;
        wr(2'd0, 8'h15);
        reselect();
        slave_frame(8'h24, g);
        check(g == 8'h00, "R11 echo frame 1", g, 8'h00);
        slave_frame(8'h35, g);
        check(g == 8'h24, "R11 echo frame 2", g, 8'h24);
        slave_frame(8'h46, g);
        check(g == 8'h35, "R11 echo frame 3", g, 8'h35);
        check(irq === 1'b0, "R10 echo wait no irq", irq, 0);
        wait_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd2, d);
        rd(2'd3, d);
        check(d == 8'h46, "R10 echo wait latched byte", d, 8'h46);
        s_ss_n_i = 1'b1;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule